// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block takes received Ethernet frames as a byte stream and stores them in a local packet memory split into 256-byte pages. The pages form a ring between a first-page and a limit-page setting. A fill pointer marks the page where the next frame starts. A host-owned boundary pointer marks the oldest page the host has not yet released. Each stored frame begins four bytes into its first page. Those four bytes are a header holding status, the page of the following frame and the stored length.

Frames are filtered before they are committed. The length must be between 13 and 2048 bytes inclusive. The destination must be the station address or the all-ones broadcast address. Frames that arrive while the halt input is set are discarded. Short frames are stored padded to 60 bytes with zeros.

The payload is written as it streams in. When the page about to be filled is not free, the block lowers its ready output until the host moves the boundary. The fill pointer only moves once the header has been written. A rejected frame therefore leaves no trace in the ring. When the frame is committed, a status output reads 0x01, and a one-cycle done pulse is raised if it is enabled.

Top module: `rx_ring_writer`

## Requirements
- R1: A frame of 12 bytes or fewer, or of more than 2048 bytes, is discarded: fill_page_o does not move and no done pulse appears.
- R2: A frame is kept only when its first six bytes equal mac_addr_i or are all 0xFF. mac_addr_i[47:40] is compared with the first byte on the stream.
- R3: A kept frame shorter than 60 bytes is stored as 60 bytes; the added bytes are 0x00.
- R4: After a commit, fill_page_o equals the old fill page advanced by ceil((L+4)/256) pages, where L is the stored length, wrapping from the limit page back to the first page.
- R5: Frame byte k is written at address page*256 + offset, where position k+4 is counted from the start of the fill page and continues into the following ring pages. No write leaves the ring.
- R6: The header in the start page holds the following bytes: offset 0 is 0x01, offset 1 is the new fill page, offset 2 is (L+4)[7:0], and offset 3 is (L+4)[15:8].
- R7: On commit, rx_stat_o becomes 0x01. rx_done_o pulses for exactly one cycle in the same cycle, but only if done_en_i is 1.
- R8: A frame whose first byte arrives while halt_i is 1 is consumed and discarded.
- R9: A byte is accepted into page q only if q differs from the boundary and the page after q differs from the boundary. Otherwise frm_ready_o is low and the frame waits.
- R10: A fill or boundary pointer at or beyond ring_limit_i is treated as ring_first_i.
- R11: After reset, fill_page_o is 0x00, rx_stat_o is 0x00, rx_done_o is 0, mem_we_o is 0 and frm_ready_o is 1.
- R12: ptr_load_i loads ptr_load_val_i into the fill pointer. If the load falls in the same cycle as a frame commit, the committed value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_i | input | 1 | Receiver halted; new frames are discarded |
| done_en_i | input | 1 | Enables the done pulse |
| mac_addr_i | input | 48 | Station address, first byte in bits 47:40 |
| ring_first_i | input | 8 | First page of the ring |
| ring_limit_i | input | 8 | Page just past the ring |
| boundary_i | input | 8 | Host-owned boundary page |
| ptr_load_i | input | 1 | Host load strobe for the fill pointer |
| ptr_load_val_i | input | 8 | Value to load into the fill pointer |
| frm_valid_i | input | 1 | Frame byte valid |
| frm_sof_i | input | 1 | First byte of a frame |
| frm_eof_i | input | 1 | Last byte of a frame |
| frm_data_i | input | 8 | Frame byte |
| frm_ready_o | output | 1 | Byte accepted when high with valid |
| mem_we_o | output | 1 | Packet memory write strobe |
| mem_addr_o | output | 16 | Packet memory byte address |
| mem_wdata_o | output | 8 | Packet memory write data |
| fill_page_o | output | 8 | Fill pointer, the page of the next frame |
| rx_stat_o | output | 8 | Receive status |
| rx_done_o | output | 1 | One-cycle frame stored event |

## Verification
Two things can fall in the same clock edge: the host loading the fill pointer, and the block committing a frame by writing the new fill page. The bench counts clock edges from the accepted last byte to the fourth header write. It raises ptr_load_i on exactly that edge and expects the committed page rather than the loaded one. A second overlap exercises the space check against a moving boundary. A frame is stalled with no free page, and the boundary is then released to leave exactly the number of pages the frame needs. The bench judges the resulting header and fill page.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RECV,
    S_DROP,
    S_PAD,
    S_HDR
  } rx_state_e;

  localparam logic [7:0] RX_STAT_OK = 8'h01;
endpackage

// File: rtl/rxr_ptr_wrap.sv
// Folds an out-of-ring pointer to the ring start and gives the page after it.
module rxr_ptr_wrap #(
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] ptr_i,
  input  logic [PAGE_W-1:0] first_i,
  input  logic [PAGE_W-1:0] limit_i,
  output logic [PAGE_W-1:0] eff_o,
  output logic [PAGE_W-1:0] nxt_o
);
  logic [PAGE_W:0] inc;

  always_comb begin
    eff_o = (ptr_i >= limit_i) ? first_i : ptr_i;
    inc   = {1'b0, eff_o} + 1'b1;
    nxt_o = (inc >= {1'b0, limit_i}) ? first_i : inc[PAGE_W-1:0];
  end
endmodule

// File: rtl/rxr_dest_filter.sv
module rxr_dest_filter #(
  parameter int AW = 48,
  parameter int IW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          first_i,
  input  logic          upd_i,
  input  logic [IW-1:0] idx_i,
  input  logic [7:0]    byte_i,
  input  logic [AW-1:0] station_i,
  output logic          keep_o
);
  localparam int NB = AW / 8;

  logic          uc_q, bc_q, uc_now, bc_now, in_addr;
  logic [AW-1:0] shifted;
  logic [7:0]    st_byte;

  always_comb begin
    in_addr = idx_i < IW'(NB);
    shifted = station_i << (8 * idx_i);
    st_byte = shifted[AW-1 -: 8];
    uc_now  = (first_i | uc_q) & (!in_addr | (byte_i == st_byte));
    bc_now  = (first_i | bc_q) & (!in_addr | (byte_i == 8'hFF));
    keep_o  = uc_now | bc_now;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uc_q <= 1'b0;
      bc_q <= 1'b0;
    end else if (upd_i) begin
      uc_q <= uc_now;
      bc_q <= bc_now;
    end
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int PAGE_W  = 8,
  parameter int OFF_W   = 8,
  parameter int MIN_LEN = 13,
  parameter int MAX_LEN = 2048,
  parameter int PAD_LEN = 60
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    halt_i,
  input  logic                    done_en_i,
  input  logic [47:0]             mac_addr_i,
  input  logic [PAGE_W-1:0]       ring_first_i,
  input  logic [PAGE_W-1:0]       ring_limit_i,
  input  logic [PAGE_W-1:0]       boundary_i,
  input  logic                    ptr_load_i,
  input  logic [PAGE_W-1:0]       ptr_load_val_i,
  input  logic                    frm_valid_i,
  input  logic                    frm_sof_i,
  input  logic                    frm_eof_i,
  input  logic [7:0]              frm_data_i,
  output logic                    frm_ready_o,
  output logic                    mem_we_o,
  output logic [PAGE_W+OFF_W-1:0] mem_addr_o,
  output logic [7:0]              mem_wdata_o,
  output logic [PAGE_W-1:0]       fill_page_o,
  output logic [7:0]              rx_stat_o,
  output logic                    rx_done_o
);
  localparam int CNT_W     = $clog2(MAX_LEN + 1);
  localparam int HDR_BYTES = 4;
  localparam int LEN_W     = 16;

  rx_state_e         state_q;
  logic [PAGE_W-1:0] fill_q, wr_page_q, start_q;
  logic [OFF_W-1:0]  wr_off_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        hdr_idx_q;

  logic [PAGE_W-1:0] fill_eff, fill_nxt, bnd_eff, bnd_nxt, cur_eff, cur_nxt;
  logic [PAGE_W-1:0] cur_page, adv_page, final_page;
  logic [OFF_W-1:0]  cur_off, adv_off;
  logic [CNT_W-1:0]  cur_cnt, cnt_nxt;
  logic [LEN_W-1:0]  tot_len;
  logic [7:0]        hdr_byte;
  logic              active, page_ok, take, too_long, keep, is_idle;

  rxr_ptr_wrap #(.PAGE_W(PAGE_W)) u_fill_wrap (
    .ptr_i(fill_q), .first_i(ring_first_i), .limit_i(ring_limit_i),
    .eff_o(fill_eff), .nxt_o(fill_nxt)
  );

  rxr_ptr_wrap #(.PAGE_W(PAGE_W)) u_bnd_wrap (
    .ptr_i(boundary_i), .first_i(ring_first_i), .limit_i(ring_limit_i),
    .eff_o(bnd_eff), .nxt_o(bnd_nxt)
  );

  rxr_ptr_wrap #(.PAGE_W(PAGE_W)) u_cur_wrap (
    .ptr_i(cur_page), .first_i(ring_first_i), .limit_i(ring_limit_i),
    .eff_o(cur_eff), .nxt_o(cur_nxt)
  );

  rxr_dest_filter #(.AW(48), .IW(CNT_W)) u_filter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .first_i  (is_idle),
    .upd_i    (take && active),
    .idx_i    (cur_cnt),
    .byte_i   (frm_data_i),
    .station_i(mac_addr_i),
    .keep_o   (keep)
  );

  always_comb begin
    is_idle  = state_q == S_IDLE;
    active   = (is_idle && frm_sof_i && !halt_i) || state_q == S_RECV;
    cur_page = is_idle ? fill_eff : wr_page_q;
    cur_off  = is_idle ? OFF_W'(HDR_BYTES) : wr_off_q;
    cur_cnt  = is_idle ? '0 : cnt_q;
    cnt_nxt  = cur_cnt + 1'b1;
    // a page is usable only if neither it nor its successor is the boundary
    page_ok  = (cur_eff != bnd_eff) && (cur_nxt != bnd_eff);
    frm_ready_o = (state_q == S_DROP) ||
                  (is_idle && !(frm_sof_i && !halt_i)) ||
                  (active && page_ok);
    take     = frm_valid_i && frm_ready_o;
    too_long = cur_cnt == CNT_W'(MAX_LEN);
    if (cur_off == '1) begin
      adv_off  = '0;
      adv_page = cur_nxt;
    end else begin
      adv_off  = cur_off + 1'b1;
      adv_page = cur_eff;
    end
    final_page = (wr_off_q == '0) ? wr_page_q : cur_nxt;
    tot_len    = LEN_W'(cnt_q) + LEN_W'(HDR_BYTES);
    unique case (hdr_idx_q)
      2'd0:    hdr_byte = RX_STAT_OK;
      2'd1:    hdr_byte = 8'(final_page);
      2'd2:    hdr_byte = tot_len[7:0];
      default: hdr_byte = tot_len[15:8];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      fill_q      <= '0;
      wr_page_q   <= '0;
      wr_off_q    <= '0;
      start_q     <= '0;
      cnt_q       <= '0;
      hdr_idx_q   <= '0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      rx_stat_o   <= '0;
      rx_done_o   <= 1'b0;
    end else begin
      mem_we_o  <= 1'b0;
      rx_done_o <= 1'b0;
      if (ptr_load_i) fill_q <= ptr_load_val_i;

      unique case (state_q)
        S_IDLE: if (take && frm_sof_i && halt_i && !frm_eof_i) state_q <= S_DROP;
        S_DROP: if (take && frm_eof_i) state_q <= S_IDLE;
        S_PAD: begin
          mem_we_o    <= 1'b1;
          mem_addr_o  <= {cur_eff, cur_off};
          mem_wdata_o <= 8'h00;
          wr_page_q   <= adv_page;
          wr_off_q    <= adv_off;
          cnt_q       <= cnt_nxt;
          if (cnt_nxt == CNT_W'(PAD_LEN)) begin
            state_q   <= S_HDR;
            hdr_idx_q <= '0;
          end
        end
        S_HDR: begin
          mem_we_o    <= 1'b1;
          mem_addr_o  <= {start_q, OFF_W'(hdr_idx_q)};
          mem_wdata_o <= hdr_byte;
          hdr_idx_q   <= hdr_idx_q + 1'b1;
          if (hdr_idx_q == 2'd3) begin
            fill_q    <= final_page;
            rx_stat_o <= RX_STAT_OK;
            rx_done_o <= done_en_i;
            state_q   <= S_IDLE;
          end
        end
        default: ;
      endcase

      if (take && active) begin
        if (is_idle) start_q <= cur_eff;
        if (too_long || !keep) begin
          state_q <= frm_eof_i ? S_IDLE : S_DROP;
        end else begin
          mem_we_o    <= 1'b1;
          mem_addr_o  <= {cur_eff, cur_off};
          mem_wdata_o <= frm_data_i;
          wr_page_q   <= adv_page;
          wr_off_q    <= adv_off;
          cnt_q       <= cnt_nxt;
          hdr_idx_q   <= '0;
          if (!frm_eof_i)                         state_q <= S_RECV;
          else if (cnt_nxt < CNT_W'(MIN_LEN))     state_q <= S_IDLE;
          else if (cnt_nxt < CNT_W'(PAD_LEN))     state_q <= S_PAD;
          else                                    state_q <= S_HDR;
        end
      end
    end
  end

  assign fill_page_o = fill_q;
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    mem_we_o,
  input logic [PAGE_W+OFF_W-1:0] mem_addr_o,
  input logic [PAGE_W-1:0]       boundary_i,
  input logic [PAGE_W-1:0]       ring_first_i,
  input logic [PAGE_W-1:0]       ring_limit_i,
  input logic [PAGE_W-1:0]       fill_page_o,
  input logic                    ptr_load_i,
  input logic                    rx_done_o,
  input logic [7:0]              rx_stat_o
);
  logic [PAGE_W-1:0] bnd_q, first_q, limit_q;
  logic [PAGE_W-1:0] wpage;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bnd_q   <= '0;
      first_q <= '0;
      limit_q <= '1;
    end else begin
      bnd_q   <= (boundary_i >= ring_limit_i) ? ring_first_i : boundary_i;
      first_q <= ring_first_i;
      limit_q <= ring_limit_i;
    end
  end

  assign wpage = mem_addr_o[PAGE_W+OFF_W-1:OFF_W];

  p_write_in_ring_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (wpage >= first_q && wpage < limit_q));

  p_skip_boundary_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> wpage != bnd_q);

  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |=> !rx_done_o);

  p_done_status_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> rx_stat_o == 8'h01);

  p_done_moves_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> !$stable(fill_page_o));

  p_fill_in_ring_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(fill_page_o) && !$past(ptr_load_i)) |->
      (fill_page_o >= ring_first_i && fill_page_o < ring_limit_i));
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .boundary_i(boundary_i), .ring_first_i(ring_first_i), .ring_limit_i(ring_limit_i),
  .fill_page_o(fill_page_o), .ptr_load_i(ptr_load_i), .rx_done_o(rx_done_o),
  .rx_stat_o(rx_stat_o)
);

// File: tb/rx_ring_writer_tb_top.sv
`timescale 1ns/1ps
module rx_ring_writer_tb_top;
  localparam int FIRST = 2;
  localparam int LIMIT = 14;
  localparam int NPG   = LIMIT - FIRST;
  localparam logic [47:0] MAC = 48'h02_11_22_33_44_55;
  localparam int NV = 9;
  // dst: 0 station, 1 broadcast, 2 other
  localparam int    V_LEN [NV] = '{64, 12, 13, 2049, 2048, 100, 80, 70, 300};
  localparam int    V_DST [NV] = '{0, 0, 1, 0, 0, 2, 0, 0, 1};
  localparam int    V_HLT [NV] = '{0, 0, 0, 0, 0, 0, 1, 0, 0};
  localparam int    V_EN  [NV] = '{1, 1, 1, 1, 1, 1, 1, 0, 1};
  localparam int    V_OK  [NV] = '{1, 0, 1, 0, 1, 0, 0, 1, 1};
  // tags: R4 normal, R1 short, R3 pad, R1 long, R1 max, R2 other dest, R8 halt, R7 no pulse, R4 two pages
  localparam string V_TAG [NV] = '{"R4", "R1", "R3", "R1", "R1", "R2", "R8", "R7", "R4"};

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic halt_i = 0, done_en_i = 1, ptr_load_i = 0;
  logic frm_valid_i = 0, frm_sof_i = 0, frm_eof_i = 0;
  logic [7:0] boundary_i = 8'd1, ptr_load_val_i = 0, frm_data_i = 0;
  logic frm_ready_o, mem_we_o, rx_done_o;
  logic [15:0] mem_addr_o;
  logic [7:0] mem_wdata_o, fill_page_o, rx_stat_o;

  logic [7:0] mem [4096];
  int checks = 0, fails = 0, ev_cnt = 0, oob = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  rx_ring_writer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .halt_i(halt_i), .done_en_i(done_en_i),
    .mac_addr_i(MAC), .ring_first_i(8'(FIRST)), .ring_limit_i(8'(LIMIT)),
    .boundary_i(boundary_i), .ptr_load_i(ptr_load_i), .ptr_load_val_i(ptr_load_val_i),
    .frm_valid_i(frm_valid_i), .frm_sof_i(frm_sof_i), .frm_eof_i(frm_eof_i),
    .frm_data_i(frm_data_i), .frm_ready_o(frm_ready_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .fill_page_o(fill_page_o),
    .rx_stat_o(rx_stat_o), .rx_done_o(rx_done_o)
  );

  always @(negedge clk_i) begin
    if (mem_we_o) begin
      if (mem_addr_o < 16'(FIRST * 256) || mem_addr_o >= 16'(LIMIT * 256)) oob++;
      else mem[mem_addr_o[11:0]] = mem_wdata_o;
    end
    if (rx_done_o) ev_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int ring_add(input int base, input int n);
    return FIRST + ((base - FIRST + n) % NPG);
  endfunction

  function automatic logic [7:0] fbyte(input int i, input int dst);
    if (i < 6) begin
      if (dst == 1) return 8'hFF;
      if (dst == 2 && i == 5) return 8'h56;
      return MAC[47 - 8 * i -: 8];
    end
    return 8'(i) ^ 8'hA5;
  endfunction

  task automatic send_frame(input int len, input int dst);
    for (int i = 0; i < len; i++) begin
      @(negedge clk_i);
      frm_valid_i = 1; frm_sof_i = (i == 0); frm_eof_i = (i == len - 1);
      frm_data_i = fbyte(i, dst);
      #1;
      while (!frm_ready_o) begin @(negedge clk_i); #1; end
      @(posedge clk_i);
    end
    @(negedge clk_i);
    frm_valid_i = 0; frm_sof_i = 0; frm_eof_i = 0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check_frame(input int old, input int len, input string tag);
    int plen, tot, nw, pos;
    plen = (len < 60) ? 60 : len;
    tot  = plen + 4;
    nw   = ring_add(old, (tot + 255) / 256);
    chk(fill_page_o == 8'(nw), tag, "fill page after commit (R4)", fill_page_o, nw);
    chk(mem[old*256+0] == 8'h01 && mem[old*256+1] == 8'(nw), tag,
        "header status/next page (R6)", {mem[old*256+0], mem[old*256+1]}, {8'h01, 8'(nw)});
    chk(mem[old*256+2] == 8'(tot) && mem[old*256+3] == 8'(tot >> 8), tag,
        "header length (R6)", {mem[old*256+3], mem[old*256+2]}, tot);
    pos = len - 1 + 4;
    chk(mem[ring_add(old, pos / 256) * 256 + pos % 256] == fbyte(len - 1, 0), tag,
        "last payload byte placement (R5)", mem[ring_add(old, pos / 256) * 256 + pos % 256], fbyte(len - 1, 0));
    if (len < 60) begin
      chk(mem[old*256+4+len] == 8'h00 && mem[old*256+63] == 8'h00, "R3", "pad bytes zero",
          mem[old*256+4+len], 0);
    end
    chk(rx_stat_o == 8'h01, "R7", "status after storage", rx_stat_o, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired: actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int cur, e0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    wait_clk(3);
    rst_ni = 1;
    wait_clk(1);
    // R11 reset state
    chk(fill_page_o == 0 && rx_stat_o == 0, "R11", "fill page/status after reset", {fill_page_o, rx_stat_o}, 0);
    chk(!rx_done_o && !mem_we_o && frm_ready_o, "R11", "done/we/ready after reset",
        {rx_done_o, mem_we_o, frm_ready_o}, 1);
    // R12 host load
    ptr_load_val_i = 8'(FIRST); ptr_load_i = 1;
    wait_clk(1);
    ptr_load_i = 0;
    chk(fill_page_o == 8'(FIRST), "R12", "host load of fill page", fill_page_o, FIRST);
    cur = FIRST;

    for (int v = 0; v < NV; v++) begin
      boundary_i = 8'((cur == FIRST) ? LIMIT - 1 : cur - 1);
      halt_i = V_HLT[v]; done_en_i = V_EN[v];
      e0 = ev_cnt;
      send_frame(V_LEN[v], V_DST[v]);
      wait_clk(80);
      if (V_OK[v] != 0) begin
        check_frame(cur, V_LEN[v], V_TAG[v]);
        cur = ring_add(cur, ((V_LEN[v] < 60 ? 60 : V_LEN[v]) + 4 + 255) / 256);
        chk(ev_cnt - e0 == V_EN[v], "R7", "done pulse count vs enable", ev_cnt - e0, V_EN[v]);
      end else begin
        chk(fill_page_o == 8'(cur) && ev_cnt == e0, V_TAG[v], "dropped frame leaves fill page",
            fill_page_o, cur);
      end
    end
    halt_i = 0; done_en_i = 1;

    // R9 back-pressure: no free page, then exactly three
    chk(cur == 4, "R4", "ring position after table walk", cur, 4);
    boundary_i = 8'd5;
    e0 = ev_cnt;
    fork send_frame(600, 0); join_none
    wait_clk(30);
    chk(!frm_ready_o && fill_page_o == 8'd4 && ev_cnt == e0, "R9", "stall with no free page",
        {frm_ready_o, fill_page_o}, 4);
    boundary_i = 8'd8;
    wait_clk(700);
    check_frame(4, 600, "R9");
    chk(fill_page_o == 8'd7, "R9", "fill page after release", fill_page_o, 7);

    // R10 pointer at limit folds to first page
    ptr_load_val_i = 8'(LIMIT); ptr_load_i = 1;
    wait_clk(1);
    ptr_load_i = 0;
    chk(fill_page_o == 8'(LIMIT), "R12", "load of out-of-ring value", fill_page_o, LIMIT);
    boundary_i = 8'(LIMIT - 1);
    send_frame(64, 1);
    wait_clk(20);
    check_frame(FIRST, 64, "R10");

    // R12 load colliding with commit: committed page wins
    send_frame(64, 0);
    wait_clk(3);
    ptr_load_val_i = 8'h09; ptr_load_i = 1;
    wait_clk(1);
    ptr_load_i = 0;
    chk(fill_page_o == 8'(FIRST + 2), "R12", "commit wins over same-cycle load", fill_page_o, FIRST + 2);
    chk(mem[(FIRST+1)*256+1] == 8'(FIRST + 2), "R6", "header next page in collision", mem[(FIRST+1)*256+1], FIRST + 2);

    chk(oob == 0, "R5", "writes outside ring", oob, 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule